// File: doc/BRIEF.md
# Completion Ring Poster

This block sits on the device side of a storage queue pair and writes completion records into a circular ring that lives in host memory. Each accepted completion request carries a command identifier, the submitting queue's identifier, the submission head pointer to report, a status code and one command-specific dword. The block packs these into a 16-byte record. It stamps the record with the current phase bit and issues it as one memory-write request at the ring base plus sixteen times the tail slot. It then advances the tail.

The host drains the ring and reports its new head through a head-update input. The poster compares that head against its own tail. It refuses new requests when one more record would overwrite a slot the host has not yet consumed. The phase bit flips every time the tail wraps to slot 0. A host polling the ring can therefore tell a freshly written record from one left over from the previous lap without keeping a count. A one-cycle pulse follows every accepted memory write, for an interrupt block outside this one.

Top module: `cq_poster`

## Requirements
- R1: After reset the tail is slot 0, the phase is 1 and the head is slot 0, no memory write is pending (`mem_valid` = 0), `posted` is 0 and `req_ready` is 1.
- R2: The 128-bit record on `mem_data` has the request dword in bits 31:0 and zero in bits 63:32. Bits 79:64 hold the submission head and bits 95:80 the queue identifier. Bits 111:96 hold the command identifier, bit 112 holds the phase and bits 127:113 hold the status.
- R3: `mem_addr` equals `ring_base` plus the tail slot times 16, with the slot taken at the moment the request is accepted.
- R4: Each accepted request advances the tail by one slot. After slot RING_SLOTS-1 the tail returns to slot 0, including when RING_SLOTS is not a power of two.
- R5: Records written on the first lap after reset or re-initialisation carry phase 1. The phase inverts each time the tail wraps to slot 0.
- R6: When (tail + 1) mod RING_SLOTS equals the head, `req_ready` is 0 and no request is accepted and no record is written.
- R7: A head update with a value below RING_SLOTS replaces the head in the cycle after `head_wr_valid`. A value of RING_SLOTS or more is ignored and leaves the full/not-full state unchanged.
- R8: While `mem_valid` is 1 and `mem_ready` is 0, `mem_addr` and `mem_data` hold steady, `mem_valid` stays 1 and `req_ready` is 0.
- R9: `posted` pulses high for exactly the one cycle after each cycle in which `mem_valid` and `mem_ready` are both 1, and at no other time.
- R10: A `ring_init` pulse returns the tail to slot 0, the phase to 1 and the head to slot 0, and discards any pending write. It also holds `req_ready` at 0 in its own cycle, and it overrides a head update in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ring_init | input | 1 | Re-initialise the ring pointers and phase |
| ring_base | input | ADDR_W | Byte address of slot 0 in host memory |
| req_valid | input | 1 | Completion request present |
| req_ready | output | 1 | Completion request accepted this cycle when high with req_valid |
| req_dw0 | input | 32 | Command-specific dword |
| req_sqid | input | 16 | Submission queue identifier |
| req_sqhd | input | 16 | Submission head pointer to report |
| req_cid | input | 16 | Command identifier |
| req_status | input | 15 | Status code |
| head_wr_valid | input | 1 | Host head update strobe |
| head_wr_value | input | 16 | New host head slot |
| mem_valid | output | 1 | Memory write request present |
| mem_ready | input | 1 | Memory write request taken |
| mem_addr | output | ADDR_W | Byte address of the record |
| mem_data | output | 128 | Record contents |
| posted | output | 1 | One-cycle pulse after each taken write |

## Verification
The bench uses a five-slot ring, so the wrap arithmetic is exercised on a size that is not a power of two. It posts records with distinct field values until the ring fills. A full ring that stalls is then told apart from an off-by-one that overwrites the head slot. The bench frees space with a legal head and offers an out-of-range head, which shows whether the bounds check exists. Posting across the wrap with the host head ahead separates a phase that inverts on wrap from one that never moves. A held-off memory port and an initialisation pulse that lands on a pending write show that records stay stable under backpressure and that re-initialisation restores slot 0, phase 1 and an empty ring.

// File: rtl/cq_pkg.sv
// Shared constants and the request record of the completion ring poster.
package cq_pkg;
    localparam int ENTRY_BYTES  = 16;
    localparam int ENTRY_BITS   = ENTRY_BYTES * 8;
    localparam int OFFSET_SHIFT = $clog2(ENTRY_BYTES);
    localparam int CID_W        = 16;
    localparam int SQID_W       = 16;
    localparam int SQHD_W       = 16;
    localparam int STATUS_W     = 15;
    localparam int HEAD_W       = 16;

    // One completion request as presented at the block's input.
    typedef struct packed {
        logic [31:0]         dw0;
        logic [SQID_W-1:0]   sqid;
        logic [SQHD_W-1:0]   sqhd;
        logic [CID_W-1:0]    cid;
        logic [STATUS_W-1:0] status;
    } cq_req_t;
endpackage

// File: rtl/cq_ring_ctrl.sv
// Ring pointer keeper: owns the tail slot, the phase and the host head.
// Assumes RING_SLOTS >= 2. Head values at or beyond RING_SLOTS are dropped.
// Full means one more record would land on the host head.
module cq_ring_ctrl #(
    parameter int RING_SLOTS = 8,
    localparam int IDX_W     = (RING_SLOTS > 2) ? $clog2(RING_SLOTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   init,
    input  logic                   advance,
    input  logic                   head_wr_valid,
    input  logic [cq_pkg::HEAD_W-1:0] head_wr_value,
    output logic [IDX_W-1:0]       tail,
    output logic                   phase,
    output logic [IDX_W-1:0]       head,
    output logic                   full
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(RING_SLOTS - 1);

    logic [IDX_W-1:0] tail_q, head_q, tail_next;
    logic             phase_q;
    logic             head_in_range;

    // Slot after the current tail, wrapping at the ring size.
    always_comb tail_next = (tail_q == LAST_SLOT) ? '0 : tail_q + 1'b1;

    // Only heads that name an existing slot are taken.
    always_comb head_in_range = (32'(head_wr_value) < RING_SLOTS);

    // Tail and phase move on each allocated slot; phase inverts on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            tail_q  <= '0;
            phase_q <= 1'b1;
        end else if (advance) begin
            tail_q <= tail_next;
            if (tail_q == LAST_SLOT)
                phase_q <= ~phase_q;
        end
    end

    // Host head register, written by legal head updates.
    always_ff @(posedge clk) begin
        if (!rst_n || init)
            head_q <= '0;
        else if (head_wr_valid && head_in_range)
            head_q <= IDX_W'(head_wr_value);
    end

    // Outputs to the rest of the poster.
    always_comb begin
        tail  = tail_q;
        phase = phase_q;
        head  = head_q;
        full  = (tail_next == head_q);
    end
endmodule

// File: rtl/cq_entry_pack.sv
// Record builder: lays a request and the phase bit out as a 16-byte record.
// Purely combinational; the second dword is always zero.
module cq_entry_pack (
    input  cq_pkg::cq_req_t                 req,
    input  logic                            phase,
    output logic [cq_pkg::ENTRY_BITS-1:0]   entry
);
    logic [31:0] dw [4];

    // Assemble each dword of the record.
    always_comb begin
        dw[0] = req.dw0;
        dw[1] = '0;
        dw[2] = {req.sqid, req.sqhd};
        dw[3] = {req.status, phase, req.cid};
    end

    // Concatenate the dwords, lowest address first.
    for (genvar i = 0; i < 4; i++) begin : g_dw
        assign entry[i*32 +: 32] = dw[i];
    end
endmodule

// File: rtl/cq_wr_stage.sv
// Memory-write holding stage: one record register with a valid/ready port.
// A flush drops a pending record. The posted pulse follows each taken write.
module cq_wr_stage #(
    parameter int ADDR_W = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          load,
    input  logic [ADDR_W-1:0]             load_addr,
    input  logic [cq_pkg::ENTRY_BITS-1:0] load_data,
    output logic                          mem_valid,
    input  logic                          mem_ready,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [cq_pkg::ENTRY_BITS-1:0] mem_data,
    output logic                          posted,
    output logic                          busy
);
    logic                          valid_q;
    logic [ADDR_W-1:0]             addr_q;
    logic [cq_pkg::ENTRY_BITS-1:0] data_q;

    // Hold a record until the memory side takes it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
        end else if (mem_ready) begin
            valid_q <= 1'b0;
        end
    end

    // Capture address and record on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (load) begin
            addr_q <= load_addr;
            data_q <= load_data;
        end
    end

    // One-cycle notice after each write the memory side takes.
    always_ff @(posedge clk) begin
        if (!rst_n) posted <= 1'b0;
        else        posted <= valid_q && mem_ready;
    end

    // Port outputs and the stall towards the request side.
    always_comb begin
        mem_valid = valid_q;
        mem_addr  = addr_q;
        mem_data  = data_q;
        busy      = valid_q && !mem_ready;
    end
endmodule

// File: rtl/cq_poster.sv
// Completion ring poster top. It accepts completion requests, packs them
// with the phase, and issues writes at base + slot*16. It refuses requests
// while the ring is full or the write port is stalled. Assumes the host
// reports only heads it has consumed up to.
module cq_poster #(
    parameter int RING_SLOTS = 8,
    parameter int ADDR_W     = 64,
    localparam int IDX_W     = (RING_SLOTS > 2) ? $clog2(RING_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ring_init,
    input  logic [ADDR_W-1:0]    ring_base,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [31:0]          req_dw0,
    input  logic [15:0]          req_sqid,
    input  logic [15:0]          req_sqhd,
    input  logic [15:0]          req_cid,
    input  logic [14:0]          req_status,
    input  logic                 head_wr_valid,
    input  logic [15:0]          head_wr_value,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [127:0]         mem_data,
    output logic                 posted
);
    import cq_pkg::*;

    logic [IDX_W-1:0]      tail_idx, head_idx;
    logic                  cur_phase, ring_full, wr_busy, accept;
    cq_req_t               req;
    logic [ENTRY_BITS-1:0] entry;
    logic [ADDR_W-1:0]     slot_addr;

    // Gather request fields into the shared record type.
    always_comb begin
        req.dw0    = req_dw0;
        req.sqid   = req_sqid;
        req.sqhd   = req_sqhd;
        req.cid    = req_cid;
        req.status = req_status;
    end

    // Ready unless initialising, full, or the write port is stalled.
    always_comb begin
        req_ready = !ring_init && !ring_full && !wr_busy;
        accept    = req_valid && req_ready;
        slot_addr = ring_base + (ADDR_W'(tail_idx) << OFFSET_SHIFT);
    end

    cq_ring_ctrl #(.RING_SLOTS(RING_SLOTS)) ring_i (
        .clk(clk), .rst_n(rst_n), .init(ring_init), .advance(accept),
        .head_wr_valid(head_wr_valid), .head_wr_value(head_wr_value),
        .tail(tail_idx), .phase(cur_phase), .head(head_idx), .full(ring_full)
    );

    cq_entry_pack pack_i (
        .req(req), .phase(cur_phase), .entry(entry)
    );

    cq_wr_stage #(.ADDR_W(ADDR_W)) wr_i (
        .clk(clk), .rst_n(rst_n), .flush(ring_init), .load(accept),
        .load_addr(slot_addr), .load_data(entry),
        .mem_valid(mem_valid), .mem_ready(mem_ready),
        .mem_addr(mem_addr), .mem_data(mem_data),
        .posted(posted), .busy(wr_busy)
    );
endmodule

// File: rtl/cq_poster_chk.sv
// Property checker for cq_poster, attached through bind below.
module cq_poster_chk #(
    parameter int RING_SLOTS = 8,
    parameter int ADDR_W     = 64,
    localparam int IDX_W     = (RING_SLOTS > 2) ? $clog2(RING_SLOTS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ring_init,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [127:0]      mem_data,
    input logic              posted,
    input logic [IDX_W-1:0]  tail,
    input logic              phase,
    input logic [IDX_W-1:0]  head
);
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(RING_SLOTS - 1);

    logic             take;
    logic [IDX_W-1:0] chk_next;
    assign take     = req_valid && req_ready;
    assign chk_next = (tail == LAST_SLOT) ? '0 : tail + 1'b1;

    // R4
    tail_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ring_init) |=> tail == $past(chk_next));

    // R5
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !ring_init && tail == LAST_SLOT) |=> phase != $past(phase));

    // R6
    no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> chk_next != head);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready && !ring_init) |=>
            mem_valid && $stable(mem_addr) && $stable(mem_data));

    // R9
    posted_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready) |=> posted);

    // R9
    posted_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        posted |-> $past(mem_valid && mem_ready));

    // R10
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ring_init |=> tail == '0 && phase && head == '0 && !mem_valid);
endmodule

bind cq_poster cq_poster_chk #(.RING_SLOTS(RING_SLOTS), .ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ring_init(ring_init),
    .req_valid(req_valid), .req_ready(req_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .posted(posted),
    .tail(tail_idx), .phase(cur_phase), .head(head_idx)
);

// File: tb/cq_poster_test.sv
// Directed bench for cq_poster with a five-slot ring.
module cq_poster_test;
    localparam int SLOTS = 5;
    localparam int AW    = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ring_init = 1'b0;
    logic [AW-1:0] ring_base = 64'h0000_0001_2000_0000;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_dw0 = '0;
    logic [15:0]   req_sqid = '0, req_sqhd = '0, req_cid = '0;
    logic [14:0]   req_status = '0;
    logic          head_wr_valid = 1'b0;
    logic [15:0]   head_wr_value = '0;
    logic          mem_valid;
    logic          mem_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [127:0]  mem_data;
    logic          posted;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cq_poster #(.RING_SLOTS(SLOTS), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .ring_init(ring_init), .ring_base(ring_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_dw0(req_dw0),
        .req_sqid(req_sqid), .req_sqhd(req_sqhd), .req_cid(req_cid),
        .req_status(req_status), .head_wr_valid(head_wr_valid),
        .head_wr_value(head_wr_value), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
        .posted(posted)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] rec(input logic [31:0] d0, input logic [15:0] sq,
            input logic [15:0] hd, input logic [15:0] cid, input logic [14:0] st,
            input logic ph);
        return {st, ph, cid, sq, hd, 32'h0, d0};
    endfunction

    // Present one request, wait for acceptance, and check the record and pulse.
    task automatic post_entry(input logic [15:0] cid, input int slot, input logic ph);
        logic [127:0] exp;
        int guard = 0;
        @(negedge clk);
        req_cid = cid; req_sqid = cid ^ 16'h00F0; req_sqhd = cid + 16'd3;
        req_status = 15'(cid * 7); req_dw0 = {cid, ~cid};
        req_valid = 1'b1;
        #1;
        while (!req_ready && guard < 50) begin
            @(negedge clk); #1; guard++;
        end
        exp = rec({cid, ~cid}, cid ^ 16'h00F0, cid + 16'd3, cid, 15'(cid * 7), ph);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_valid === 1'b1, "R8 mem_valid after accept", 128'(mem_valid), 128'd1);
        chk(mem_addr === ring_base + AW'(slot * 16), "R3 slot address",
            128'(mem_addr), 128'(ring_base + AW'(slot * 16)));
        chk(mem_data === exp, "R2 R5 record layout and phase", mem_data, exp);
        @(negedge clk);
        chk(posted === 1'b1 && mem_valid === 1'b0, "R9 posted pulse",
            128'({posted, mem_valid}), 128'b10);
        @(negedge clk);
        chk(posted === 1'b0, "R9 pulse is one cycle", 128'(posted), 128'd0);
    endtask

    task automatic set_head(input logic [15:0] v);
        @(negedge clk);
        head_wr_valid = 1'b1; head_wr_value = v;
        @(negedge clk);
        head_wr_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(req_ready === 1 && mem_valid === 0 && posted === 0, "R1 reset state",
            128'({req_ready, mem_valid, posted}), 128'b100);
    endtask

    // Fill the ring: four records fit in five slots; the fifth stalls.
    task automatic t_fill;
        for (int i = 0; i < SLOTS - 1; i++) post_entry(16'(16'h0A00 + i), i, 1'b1);
        @(negedge clk);
        req_valid = 1'b1; #1;
        chk(req_ready === 1'b0, "R6 ready low when full", 128'(req_ready), 128'd0);
        @(negedge clk); #1;
        chk(mem_valid === 1'b0, "R6 no write while full", 128'(mem_valid), 128'd0);
        chk(req_ready === 1'b0, "R6 still full", 128'(req_ready), 128'd0);
        req_valid = 1'b0;
    endtask

    // Free space, wrap the tail, reject an out-of-range head.
    task automatic t_wrap;
        set_head(16'd3);
        chk(req_ready === 1'b1, "R7 head update frees space", 128'(req_ready), 128'd1);
        post_entry(16'h0B04, 4, 1'b1);
        post_entry(16'h0B00, 0, 1'b0);  // R5: first record after wrap has phase 0
        post_entry(16'h0B01, 1, 1'b0);
        #1;
        chk(req_ready === 1'b0, "R4 R6 full after wrap", 128'(req_ready), 128'd0);
        set_head(16'd9);
        chk(req_ready === 1'b0, "R7 out-of-range head ignored", 128'(req_ready), 128'd0);
        set_head(16'd2);
        chk(req_ready === 1'b1, "R7 legal head accepted", 128'(req_ready), 128'd1);
    endtask

    // Hold the memory port off and watch the record stay put.
    task automatic t_backpressure;
        logic [AW-1:0]  a0;
        logic [127:0]   d0;
        @(negedge clk);
        mem_ready = 1'b0;
        req_cid = 16'h0C02; req_sqid = 16'h0777; req_sqhd = 16'h0005;
        req_status = 15'h1234; req_dw0 = 32'hDEAD_BEEF; req_valid = 1'b1;
        @(negedge clk);
        req_cid = 16'h0C03;
        a0 = mem_addr; d0 = mem_data;
        chk(d0 === rec(32'hDEAD_BEEF, 16'h0777, 16'h0005, 16'h0C02, 15'h1234, 1'b0),
            "R2 record under backpressure", d0,
            rec(32'hDEAD_BEEF, 16'h0777, 16'h0005, 16'h0C02, 15'h1234, 1'b0));
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(mem_valid === 1 && mem_addr === a0 && mem_data === d0,
                "R8 held record stable", 128'(mem_addr), 128'(a0));
            chk(req_ready === 1'b0 && posted === 1'b0, "R8 request stalled",
                128'({req_ready, posted}), 128'd0);
        end
        req_valid = 1'b0;
        mem_ready = 1'b1;
        @(negedge clk); #1;
        chk(posted === 1'b1, "R9 pulse after late accept", 128'(posted), 128'd1);
    endtask

    // Initialise over a pending write, then refill from slot 0.
    task automatic t_init;
        @(negedge clk);
        mem_ready = 1'b0;
        req_cid = 16'h0D00; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ring_init = 1'b1;
        head_wr_valid = 1'b1; head_wr_value = 16'd4;
        #1;
        chk(req_ready === 1'b0, "R10 ready low during init", 128'(req_ready), 128'd0);
        @(negedge clk);
        ring_init = 1'b0; head_wr_valid = 1'b0;
        #1;
        chk(mem_valid === 1'b0, "R10 pending write dropped", 128'(mem_valid), 128'd0);
        chk(req_ready === 1'b1, "R10 ready after init", 128'(req_ready), 128'd1);
        mem_ready = 1'b1;
        ring_base = 64'h0000_0002_0000_1000;
        for (int i = 0; i < SLOTS - 1; i++) post_entry(16'(16'h0E00 + i), i, 1'b1);
        #1;
        chk(req_ready === 1'b0, "R10 head reset to slot 0", 128'(req_ready), 128'd0);
    endtask

    initial begin
        t_reset();
        t_fill();
        t_wrap();
        t_backpressure();
        t_init();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule